// File: doc/BRIEF.md
# SMBus Indexed Block-Transfer Target

This block is a serial-bus target that fronts a small byte-wide register file, such as the control bytes of a clock generator. It watches the two bus lines through synchronisers, picks out start, repeated-start and stop conditions, and answers a 7-bit address. That address is a base value offset by a strap input.

A host writes by sending an index, a byte count and then the data bytes. The data go to consecutive registers from the index onward. A host reads by first writing an index, then issuing a repeated start with the read address. The target answers with a count byte taken from a dedicated count register, followed by register contents from the index onward, until the host refuses a byte.

The register file itself sits outside the block. The block reaches it through a one-cycle write strobe and a combinational read port. It has no clock stretching, no packet error code and no bus timeout.

Top module: `smbt_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal BASE_ADDR plus the strap value (default 0x68, so 0xD0 writes and 0xD1 reads with the strap at 0). Bit 0 is the direction, 1 meaning read.
- R2: After a non-matching address byte, the target leaves SDA released through the acknowledge slot and every later bit, and performs no register write, until the next start.
- R3: In a write, the target acknowledges the address byte, the index byte, the count byte and each data byte that fits within the count. It acknowledges by pulling SDA low during the ninth clock.
- R4: In a write with index N and count X, the data bytes are written to registers N through N+X-1 in order. Each write is a single-cycle strobe, and no other register changes.
- R5: Data bytes beyond the count, including every data byte when the count is 0, are not acknowledged and are not written.
- R6: In a read, the first byte the target sends is the content of register COUNT_IDX (default 8). It sends bytes most significant bit first.
- R7: Each byte the host acknowledges is followed by the register at the next index, starting at index N.
- R8: A host NACK ends transmission. The target keeps SDA released on all further clocks until a start.
- R9: A stop or a start at any point aborts the transfer. Writes already strobed stay in place.
- R10: The target starts driving SDA low only while SCL is low.
- R11: During reset and after it, SDA is released and no write strobe is issued.
- R12: The index pointer wraps from 0xFF to 0x00, for both writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | SEL_W | Address strap, added to BASE_ADDR |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | IDX_W | Register write index |
| reg_wdata | output | 8 | Register write data |
| reg_raddr | output | IDX_W | Register read index |
| reg_rdata | input | 8 | Register read data, combinational from reg_raddr |

## Verification
The bench builds the block with its default parameters: base address 0x68, a two-bit strap, an eight-bit index and the count register at 8. With an eight-bit index the 256-entry register model is small enough to compare in full after every transaction, so a stray write anywhere is caught. Near-exhaustive sweeps run every strap value and combine several start indices, including one that wraps past 0xFF, with counts of 0 to 5. The bench also covers over-long writes, reads of varying length that cross the count register, and transfers cut short by a stop or a repeated start.

// File: rtl/smbt_pkg.sv
// Package: shared state encoding for the indexed block-transfer target.
// Assumes byte-wide registers; all bus bytes are 8 bits.
package smbt_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,    // no transfer in progress
        ST_ADDR,    // shifting in the address byte
        ST_INDEX,   // shifting in the start index
        ST_COUNT,   // shifting in the write byte count
        ST_WDATA,   // shifting in write data
        ST_ACK,     // driving the acknowledge slot
        ST_TX,      // shifting a byte out to the host
        ST_TX_ACK,  // sampling the host acknowledge
        ST_WAIT     // silent until the next start
    } smbt_state_e;
endpackage

// File: rtl/smbt_bus_mon.sv
// Module: smbt_bus_mon
// Synchronises SCL/SDA into clk and produces single-cycle events for
// SCL edges, start (SDA falls with SCL high) and stop (SDA rises with
// SCL high). Assumes clk is several times faster than the bus.
module smbt_bus_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    // Purpose: shift both lines through the synchroniser chain, idle high.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Purpose: hold the previous synchronised values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_prev;
    assign scl_fall = ~scl_s & scl_prev;
    assign start_ev = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_ev  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/smbt_ctrl.sv
// Module: smbt_ctrl
// Byte-level protocol engine: address match, index/count/data reception
// with per-byte acknowledge, and count-then-data transmission for reads.
// Assumes bus events from smbt_bus_mon and a combinational register read.
module smbt_ctrl
    import smbt_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR = 7'h68,
    parameter int         SEL_W     = 2,
    parameter int         IDX_W     = 8,
    parameter int         COUNT_IDX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [SEL_W-1:0]  addr_sel,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_waddr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic [IDX_W-1:0]  reg_raddr,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W);
    localparam logic [IDX_W-1:0] CNT_PTR = IDX_W'(COUNT_IDX);

    smbt_state_e       state;
    smbt_state_e       nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] wr_left;
    logic [IDX_W-1:0]  ptr;
    logic              ack_drv;
    logic              host_ack;
    logic [6:0]        my_addr;
    logic [BYTE_W-1:0] rx_next;
    logic              byte_done;

    // Purpose: derive own address and the byte being completed.
    assign my_addr   = BASE_ADDR + 7'(addr_sel);
    assign rx_next   = {rx_sh[BYTE_W-2:0], sda_s};
    assign byte_done = scl_rise && (bit_cnt == LAST_RX);

    // Purpose: count byte is read while the address byte arrives, else the pointer.
    assign reg_raddr = (state == ST_ADDR) ? CNT_PTR : ptr;

    // Purpose: protocol state machine, bit shifting and register strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            nxt       <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            wr_left   <= '0;
            ptr       <= '0;
            ack_drv   <= 1'b0;
            host_ack  <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (start_ev) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_oe   <= 1'b0;
                ack_drv  <= 1'b0;
                host_ack <= 1'b0;
            end else if (stop_ev) begin
                state    <= ST_IDLE;
                bit_cnt  <= '0;
                sda_oe   <= 1'b0;
                ack_drv  <= 1'b0;
                host_ack <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_next;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_done) begin
                            bit_cnt <= '0;
                            state   <= ST_ACK;
                            case (state)
                                ST_ADDR: begin
                                    if (rx_next[BYTE_W-1:1] != my_addr) begin
                                        state <= ST_WAIT;
                                    end else if (rx_next[0]) begin
                                        tx_sh <= reg_rdata;
                                        nxt   <= ST_TX;
                                    end else begin
                                        nxt <= ST_INDEX;
                                    end
                                end
                                ST_INDEX: begin
                                    ptr <= rx_next[IDX_W-1:0];
                                    nxt <= ST_COUNT;
                                end
                                ST_COUNT: begin
                                    wr_left <= rx_next;
                                    nxt     <= ST_WDATA;
                                end
                                default: begin
                                    if (wr_left == '0) begin
                                        state <= ST_WAIT;
                                    end else begin
                                        reg_we    <= 1'b1;
                                        reg_waddr <= ptr;
                                        reg_wdata <= rx_next;
                                        ptr       <= ptr + 1'b1;
                                        wr_left   <= wr_left - 1'b1;
                                        nxt       <= ST_WDATA;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_drv) begin
                                sda_oe  <= 1'b1;
                                ack_drv <= 1'b1;
                            end else begin
                                ack_drv <= 1'b0;
                                state   <= nxt;
                                sda_oe  <= (nxt == ST_TX) ? ~tx_sh[BYTE_W-1] : 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall) begin
                            if (bit_cnt == LAST_TX) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_TX_ACK;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            if (!sda_s) begin
                                tx_sh    <= reg_rdata;
                                ptr      <= ptr + 1'b1;
                                host_ack <= 1'b1;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                        if (scl_fall && host_ack) begin
                            host_ack <= 1'b0;
                            state    <= ST_TX;
                            sda_oe   <= ~tx_sh[BYTE_W-1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_SDA_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s) else $error("sda driven low while scl high"); // R10
    AST_START_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR && !sda_oe)) else $error("start did not restart"); // R9
    AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_oe)) else $error("stop did not idle"); // R9
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we) else $error("write strobe longer than a cycle"); // R4
    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (!sda_oe && !reg_we)) else $error("activity while ignoring bus"); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe) else $error("driving while idle"); // R11
endmodule

// File: rtl/smbt_target.sv
// Module: smbt_target
// Top of the indexed block-transfer target: bus monitor plus protocol
// engine. Assumes an external open-drain pad driven by sda_oe and a
// register file with a one-cycle write strobe and combinational read.
module smbt_target
    import smbt_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR   = 7'h68,
    parameter int         SEL_W       = 2,
    parameter int         IDX_W       = 8,
    parameter int         COUNT_IDX   = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  addr_sel,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_waddr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic [IDX_W-1:0]  reg_raddr,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    smbt_bus_mon #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smbt_ctrl #(
        .BASE_ADDR (BASE_ADDR),
        .SEL_W     (SEL_W),
        .IDX_W     (IDX_W),
        .COUNT_IDX (COUNT_IDX)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .addr_sel  (addr_sel),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: tb/test_smbt_target.sv
module test_smbt_target;
    localparam logic [6:0] BASE = 7'h68;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl;
    logic       host_low;
    logic [1:0] sel;
    logic       dut_oe;
    logic       we;
    logic [7:0] waddr, wdata, raddr, rdata;
    logic       sda_line;
    logic [7:0] mem [256];
    logic [7:0] expv [256];
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    assign sda_line = !(host_low || dut_oe);
    assign rdata    = mem[raddr];

    smbt_target i_smbt_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .addr_sel  (sel),
        .sda_oe    (dut_oe),
        .reg_we    (we),
        .reg_waddr (waddr),
        .reg_wdata (wdata),
        .reg_raddr (raddr),
        .reg_rdata (rdata)
    );

    // Register file model: preset pattern in reset, written by the strobe.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic q;
        repeat (6) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        q; host_low = !b; q; scl = 1'b1; q; q; scl = 1'b0;
    endtask

    task automatic get_bit(output logic b, output logic stable);
        logic a;
        host_low = 1'b0; q; q; scl = 1'b1; q; a = sda_line; q; b = sda_line;
        stable = (a == b); scl = 1'b0;
    endtask

    task automatic start_c;
        q; host_low = 1'b0; q; scl = 1'b1; q; host_low = 1'b1; q; scl = 1'b0;
    endtask

    task automatic stop_c;
        q; host_low = 1'b1; q; scl = 1'b1; q; host_low = 1'b0; q; q;
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic b, st;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b, st);
        ack = !b;
    endtask

    task automatic rd_byte(output logic [7:0] v, input logic ack_it);
        logic b, st, all_st;
        all_st = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b, st);
            v[i] = b;
            all_st &= st;
        end
        chk(all_st, "R10 data stable while SCL high", 0, 0);
        put_bit(!ack_it);
    endtask

    function automatic logic [7:0] pat(input int n, input int i, input int x);
        return 8'((n * 7 + i * 29 + x) ^ 8'h3C);
    endfunction

    task automatic cmp_mem(input string req);
        int bad = -1;
        for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== expv[i]) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(mem[bad]), int'(expv[bad]));
    endtask

    // Write X bytes declared, nsend sent, starting at index n; fixed >= 0 forces data.
    task automatic blk_write(input int n, input int x, input int nsend, input int fixed);
        logic ack;
        logic [7:0] d;
        start_c;
        wr_byte({BASE + 7'(sel), 1'b0}, ack); chk(ack, "R3 address ack", ack, 1);
        wr_byte(8'(n), ack);                 chk(ack, "R3 index ack", ack, 1);
        wr_byte(8'(x), ack);                 chk(ack, "R3 count ack", ack, 1);
        for (int i = 0; i < nsend; i++) begin
            d = (fixed >= 0) ? 8'(fixed) : pat(n, i, x);
            wr_byte(d, ack);
            if (i < x) begin
                expv[(n + i) & 255] = d;
                chk(ack, "R3 data ack", ack, 1);
            end else begin
                chk(!ack, "R5 excess byte nack", ack, 0);
            end
        end
        stop_c;
        cmp_mem("R4 R5 R12 register contents");
    endtask

    task automatic blk_read(input int n);
        logic ack, b, st, quiet;
        logic [7:0] v;
        int len;
        start_c;
        wr_byte({BASE + 7'(sel), 1'b0}, ack); chk(ack, "R1 write address ack", ack, 1);
        wr_byte(8'(n), ack);                 chk(ack, "R3 index ack", ack, 1);
        start_c;
        wr_byte({BASE + 7'(sel), 1'b1}, ack); chk(ack, "R1 read address ack", ack, 1);
        len = int'(expv[8]);
        rd_byte(v, len != 0);
        chk(v == expv[8], "R6 count byte", v, expv[8]);
        for (int i = 0; i < len; i++) begin
            rd_byte(v, i != len - 1);
            chk(v == expv[(n + i) & 255], "R7 R12 read data", v, expv[(n + i) & 255]);
        end
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin get_bit(b, st); quiet &= b; end
        chk(quiet, "R8 released after nack", quiet, 1);
        stop_c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report;
    end

    initial begin
        logic ack, b, st, quiet;
        logic [7:0] v;
        rst_n = 1'b0; scl = 1'b1; host_low = 1'b0; sel = 2'd0;
        for (int i = 0; i < 256; i++) expv[i] = 8'(i) ^ 8'hA5;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(!dut_oe && !we, "R11 reset outputs", {dut_oe, we}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(!dut_oe && !we && sda_line, "R11 idle after reset", {dut_oe, we}, 0);
        cmp_mem("R11 no writes after reset");

        // Address strap sweep: own address acked, a neighbour's ignored.
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            start_c;
            wr_byte({BASE + 7'(s), 1'b0}, ack);
            chk(ack, "R1 strap address ack", ack, 1);
            stop_c;
            start_c;
            wr_byte({BASE + 7'((s + 1) % 4), 1'b0}, ack);
            chk(!ack, "R2 foreign address nack", ack, 0);
            wr_byte(8'h10, ack); wr_byte(8'h01, ack); wr_byte(8'hEE, ack);
            chk(!ack, "R2 bus ignored", ack, 0);
            stop_c;
            start_c;
            wr_byte({BASE + 7'((s + 2) % 4), 1'b1}, ack);
            quiet = !ack;
            for (int i = 0; i < 9; i++) begin get_bit(b, st); quiet &= b; end
            chk(quiet, "R2 foreign read silent", quiet, 1);
            stop_c;
            cmp_mem("R2 no writes on foreign address");
        end
        sel = 2'd0;

        // Write sweep over start index and count, including wrap past 0xFF.
        foreach (expv[k]) if (k < 0) $display("unreachable");
        for (int a = 0; a < 4; a++) begin
            for (int x = 1; x <= 4; x++) begin
                blk_write((a == 0) ? 0 : (a == 1) ? 3 : (a == 2) ? 32 : 253, x, x, -1);
            end
        end
        blk_write(64, 2, 5, -1);   // R5 excess bytes
        blk_write(80, 0, 2, -1);   // R5 zero count

        // Reads with count 3, including wrap, then count 5 across the count register.
        blk_write(8, 1, 1, 3);
        blk_read(0);
        blk_read(6);
        blk_read(32);
        blk_read(254);             // R12 read wrap
        blk_write(8, 1, 1, 5);
        blk_read(4);
        blk_write(8, 1, 1, 0);
        blk_read(16);

        // R9: stop in the middle of a write keeps the committed byte.
        start_c;
        wr_byte({BASE, 1'b0}, ack); wr_byte(8'h60, ack); wr_byte(8'd3, ack);
        wr_byte(8'h9A, ack); expv[8'h60] = 8'h9A;
        stop_c;
        cmp_mem("R9 stop abort keeps write");

        // R9: repeated start mid-write, then a read answers normally.
        start_c;
        wr_byte({BASE, 1'b0}, ack); wr_byte(8'h70, ack); wr_byte(8'd3, ack);
        wr_byte(8'h4B, ack); expv[8'h70] = 8'h4B;
        start_c;
        wr_byte({BASE, 1'b1}, ack);
        chk(ack, "R9 read after repeated start", ack, 1);
        rd_byte(v, 1'b0);
        chk(v == expv[8], "R9 R6 count after abort", v, expv[8]);
        stop_c;
        cmp_mem("R9 repeated start keeps write");

        report;
    end
endmodule